// File: doc/BRIEF.md
# Flash Embedded-Operation Status Engine

This block sits beside the command decoder of an on-chip flash array. It produces the status byte that a host polls while a byte program or an erase runs by itself. It also manages the collection window in which further sector erase commands can be added to an erase that has not yet begun. The decoder passes in single-cycle start pulses along with the latched sector index and the most significant bit of the byte being programmed. The block also receives the per-sector protection mask, the host read strobe, a flag from the pulse engine saying its retry limit was exceeded, and a one-microsecond tick. The actual array work is modelled as a busy interval measured in ticks, and every interval length is a parameter.

While busy, the host reads the status byte to track progress. Bit 7 gives polled data, bit 6 toggles on each read, bit 5 is a sticky failure flag, and bit 3 tells whether the erase has started. The 8-bit erase mask reports which sectors the erase will act on.

Top module: `flash_op_status`

## Requirements
- R1: After reset the block is idle: busy is 0, the erase mask is 0 and the status byte is 0x80.
- R2: The status byte always has bits 4, 2, 1 and 0 at 0. After start_prog to an unprotected sector, busy is 1 for exactly PROG_US ticks, and bit 7 reads the inverse of prog_msb while bit 3 reads 0. When the interval ends, busy drops and bit 7 reads prog_msb itself.
- R3: During any erase activity, whether the window, the erase itself or a dummy interval, bit 7 reads 0. After an erase completes, bit 7 reads 1.
- R4: Each rd_strobe taken while busy inverts status bit 6 for the following read. A rd_strobe taken while idle leaves bit 6 unchanged.
- R5: A limit_hit during a running program or erase sets bit 5 and holds busy at 1, and bit 6 keeps toggling. Ticks and other commands do not change this. Only cmd_reset clears bit 5 and returns the block to idle.
- R6: start_serase opens a window of WIN_US ticks and sets erase-mask bit N, where N is serase_sect. Bit 3 reads 0 while the window is open. Each further start_serase inside the window sets its bit and restarts the full window, even when it arrives on the tick that would have closed the window. When the window closes, bit 3 reads 1.
- R7: Inside the window, any of cmd_reset, cmd_other, start_prog or start_cerase aborts the operation: busy becomes 0, the erase mask becomes 0, and no new operation starts.
- R8: While a program, an erase or a dummy interval runs, every command pulse is ignored. Busy, the erase mask and the remaining time are unaffected.
- R9: start_prog to a sector whose prot_mask bit is 1 holds busy for PPROT_US ticks, with the same status as a program, and then returns to idle.
- R10: When the window closes, protected sectors are removed from the erase mask. If none remain, busy lasts EPROT_US ticks with the mask at 0. Otherwise the erase lasts ERASE_US ticks.
- R11: start_cerase skips the window. The erase mask becomes the inverse of prot_mask and bit 3 reads 1 at once. If every sector is protected, the dummy interval of R10 applies.
- R12: Whenever busy is 0, the erase mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| start_prog | input | 1 | Byte program command accepted |
| prog_sect | input | SW | Sector index of the program address |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| start_serase | input | 1 | Sector erase command accepted |
| serase_sect | input | SW | Sector index of the sector erase |
| start_cerase | input | 1 | Chip erase command accepted |
| cmd_reset | input | 1 | Reset command written |
| cmd_other | input | 1 | Any other command write |
| prot_mask | input | NS | Per-sector protection, bit i = sector i |
| rd_strobe | input | 1 | Host status read cycle |
| limit_hit | input | 1 | Pulse-count limit exceeded |
| status | output | 8 | Status byte |
| busy | output | 1 | Embedded operation or window active |
| erase_mask | output | NS | Sectors selected for erase |

## Verification
The window's expiry and a new sector erase command can land in the same cycle: the last tick closes the window while start_serase arrives. The bench provokes this by driving us_tick and start_serase together on the final window tick. The add must win. Bit 3 stays 0, the new sector appears in the mask, and a full WIN_US further ticks are needed before bit 3 rises. Reads that land on the tick that completes an operation, and limit flags during long fail holds, are mixed into randomized program and erase runs.

// File: rtl/fos_pkg.sv
package fos_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROG   = 3'd1,
    ST_PDUMMY = 3'd2,
    ST_WIN    = 3'd3,
    ST_ERASE  = 3'd4,
    ST_EDUMMY = 3'd5,
    ST_FAIL   = 3'd6
  } fos_state_e;

  function automatic logic [7:0] fos_pack(input logic b7, input logic b6,
                                          input logic b5, input logic b3);
    return {b7, b6, b5, 1'b0, b3, 3'b000};
  endfunction

endpackage

// File: rtl/fos_timer.sv
module fos_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (tick && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = tick && (cnt_q == '0);

endmodule

// File: rtl/fos_mask.sv
module fos_mask #(
  parameter int NS = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_all,
  input  logic          prune,
  input  logic          add,
  input  logic [SW-1:0] add_idx,
  input  logic [NS-1:0] prot,
  output logic [NS-1:0] mask
);

  logic [NS-1:0] mask_q;
  logic [NS-1:0] mask_d;
  logic          mask_en;

  assign mask_en = clr || set_all || prune || add;

  for (genvar i = 0; i < NS; i++) begin : g_bit
    assign mask_d[i] = clr     ? 1'b0 :
                       set_all ? ~prot[i] :
                       prune   ? (mask_q[i] & ~prot[i]) :
                       (add && (add_idx == SW'(i))) ? 1'b1 :
                       mask_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask = mask_q;

endmodule

// File: rtl/fos_status.sv
module fos_status
  import fos_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fos_state_e state,
  input  logic       kind_prog,
  input  logic       data7,
  input  logic       done7,
  input  logic       rd_strobe,
  output logic [7:0] status,
  output logic       busy
);

  logic tog_q;
  logic tog_en;
  logic b7;
  logic b5;
  logic b3;

  assign busy   = (state != ST_IDLE);
  assign tog_en = rd_strobe && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= ~tog_q;
    end
  end

  always_comb begin
    b7 = done7;
    b5 = 1'b0;
    b3 = 1'b0;
    unique case (state)
      ST_PROG, ST_PDUMMY: b7 = ~data7;
      ST_WIN:             b7 = 1'b0;
      ST_ERASE, ST_EDUMMY: begin
        b7 = 1'b0;
        b3 = 1'b1;
      end
      ST_FAIL: begin
        b7 = kind_prog ? ~data7 : 1'b0;
        b5 = 1'b1;
        b3 = ~kind_prog;
      end
      default: b7 = done7;
    endcase
  end

  assign status = fos_pack(b7, tog_q, b5, b3);

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import fos_pkg::*;
#(
  parameter int NS       = 8,
  parameter int SW       = 3,
  parameter int PROG_US  = 16,
  parameter int ERASE_US = 1000000,
  parameter int WIN_US   = 50,
  parameter int PPROT_US = 2,
  parameter int EPROT_US = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic          start_prog,
  input  logic [SW-1:0] prog_sect,
  input  logic          prog_msb,
  input  logic          start_serase,
  input  logic [SW-1:0] serase_sect,
  input  logic          start_cerase,
  input  logic          cmd_reset,
  input  logic          cmd_other,
  input  logic [NS-1:0] prot_mask,
  input  logic          rd_strobe,
  input  logic          limit_hit,
  output logic [7:0]    status,
  output logic          busy,
  output logic [NS-1:0] erase_mask
);

  localparam int MAX_A = (PROG_US  > ERASE_US) ? PROG_US  : ERASE_US;
  localparam int MAX_B = (WIN_US   > PPROT_US) ? WIN_US   : PPROT_US;
  localparam int MAX_C = (MAX_A    > MAX_B)    ? MAX_A    : MAX_B;
  localparam int MAXD  = (MAX_C    > EPROT_US) ? MAX_C    : EPROT_US;
  localparam int CW    = $clog2(MAXD) + 1;

  localparam logic [CW-1:0] LD_PROG  = CW'(PROG_US - 1);
  localparam logic [CW-1:0] LD_ERASE = CW'(ERASE_US - 1);
  localparam logic [CW-1:0] LD_WIN   = CW'(WIN_US - 1);
  localparam logic [CW-1:0] LD_PPROT = CW'(PPROT_US - 1);
  localparam logic [CW-1:0] LD_EPROT = CW'(EPROT_US - 1);

  fos_state_e    state_q, state_d;
  logic          kind_q, kind_d;
  logic          data7_q, data7_d;
  logic          done7_q, done7_d;

  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_exp;

  logic          m_clr, m_set, m_prune, m_add;
  logic          win_abort;
  logic [NS-1:0] win_keep;

  assign win_abort = cmd_reset || cmd_other || start_prog || start_cerase;
  assign win_keep  = erase_mask & ~prot_mask;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    data7_d = data7_q;
    done7_d = done7_q;
    t_load  = 1'b0;
    t_val   = '0;
    m_clr   = 1'b0;
    m_set   = 1'b0;
    m_prune = 1'b0;
    m_add   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_prog) begin
          kind_d  = 1'b1;
          data7_d = prog_msb;
          t_load  = 1'b1;
          if (prot_mask[prog_sect]) begin
            state_d = ST_PDUMMY;
            t_val   = LD_PPROT;
          end else begin
            state_d = ST_PROG;
            t_val   = LD_PROG;
          end
        end else if (start_cerase) begin
          kind_d = 1'b0;
          m_set  = 1'b1;
          t_load = 1'b1;
          if (&prot_mask) begin
            state_d = ST_EDUMMY;
            t_val   = LD_EPROT;
          end else begin
            state_d = ST_ERASE;
            t_val   = LD_ERASE;
          end
        end else if (start_serase) begin
          kind_d  = 1'b0;
          m_add   = 1'b1;
          t_load  = 1'b1;
          t_val   = LD_WIN;
          state_d = ST_WIN;
        end
      end
      ST_PROG: begin
        if (limit_hit) begin
          state_d = ST_FAIL;
        end else if (t_exp) begin
          state_d = ST_IDLE;
          done7_d = data7_q;
        end
      end
      ST_PDUMMY: begin
        if (t_exp) begin
          state_d = ST_IDLE;
          done7_d = data7_q;
        end
      end
      ST_WIN: begin
        if (win_abort) begin
          state_d = ST_IDLE;
          m_clr   = 1'b1;
        end else if (start_serase) begin
          m_add  = 1'b1;
          t_load = 1'b1;
          t_val  = LD_WIN;
        end else if (t_exp) begin
          m_prune = 1'b1;
          t_load  = 1'b1;
          if (win_keep == '0) begin
            state_d = ST_EDUMMY;
            t_val   = LD_EPROT;
          end else begin
            state_d = ST_ERASE;
            t_val   = LD_ERASE;
          end
        end
      end
      ST_ERASE: begin
        if (limit_hit) begin
          state_d = ST_FAIL;
        end else if (t_exp) begin
          state_d = ST_IDLE;
          m_clr   = 1'b1;
          done7_d = 1'b1;
        end
      end
      ST_EDUMMY: begin
        if (t_exp) begin
          state_d = ST_IDLE;
          m_clr   = 1'b1;
          done7_d = 1'b1;
        end
      end
      ST_FAIL: begin
        if (cmd_reset) begin
          state_d = ST_IDLE;
          m_clr   = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        m_clr   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= 1'b0;
      data7_q <= 1'b0;
      done7_q <= 1'b1;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      data7_q <= data7_d;
      done7_q <= done7_d;
    end
  end

  fos_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .load     (t_load),
    .load_val (t_val),
    .expire   (t_exp)
  );

  fos_mask #(.NS(NS), .SW(SW)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (m_clr),
    .set_all (m_set),
    .prune   (m_prune),
    .add     (m_add),
    .add_idx (serase_sect),
    .prot    (prot_mask),
    .mask    (erase_mask)
  );

  fos_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .kind_prog (kind_q),
    .data7     (data7_q),
    .done7     (done7_q),
    .rd_strobe (rd_strobe),
    .status    (status),
    .busy      (busy)
  );

endmodule

// File: rtl/fos_checker.sv
module fos_checker
  import fos_pkg::*;
#(
  parameter int NS = 8,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input fos_state_e    state_q,
  input logic          data7_q,
  input logic [7:0]    status,
  input logic          busy,
  input logic [NS-1:0] erase_mask,
  input logic          rd_strobe,
  input logic          cmd_reset,
  input logic          cmd_other,
  input logic          start_prog,
  input logic          start_cerase,
  input logic          start_serase,
  input logic [SW-1:0] serase_sect
);

  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_strobe) |=> (status[6] != $past(status[6])));

  p_toggle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rd_strobe) |=> $stable(status[6]));

  p_fail_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !cmd_reset) |=> status[5]);

  p_fail_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> busy);

  p_prog_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG) |-> (status[7] != data7_q));

  p_erase_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIN || state_q == ST_ERASE || state_q == ST_EDUMMY) |-> !status[7]);

  p_win_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIN) |-> !status[3]);

  p_mask_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIN && start_serase && !cmd_reset && !cmd_other &&
     !start_prog && !start_cerase) |=> erase_mask[$past(serase_sect)]);

  p_win_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WIN && (cmd_reset || cmd_other || start_prog || start_cerase))
      |=> (!busy && erase_mask == '0));

  p_mask_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (erase_mask == '0));

endmodule

bind flash_op_status fos_checker #(.NS(NS), .SW(SW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_q      (state_q),
  .data7_q      (data7_q),
  .status       (status),
  .busy         (busy),
  .erase_mask   (erase_mask),
  .rd_strobe    (rd_strobe),
  .cmd_reset    (cmd_reset),
  .cmd_other    (cmd_other),
  .start_prog   (start_prog),
  .start_cerase (start_cerase),
  .start_serase (start_serase),
  .serase_sect  (serase_sect)
);

// File: tb/sim_flash_op_status.sv
`timescale 1ns/1ps
module sim_flash_op_status;
  localparam int NS = 8, SW = 3;
  localparam int P_PROG = 5, P_ERASE = 7, P_WIN = 4, P_PPROT = 2, P_EPROT = 3;

  logic clk, rst_n, us_tick, start_prog, prog_msb, start_serase, start_cerase;
  logic cmd_reset, cmd_other, rd_strobe, limit_hit;
  logic [SW-1:0] prog_sect, serase_sect;
  logic [NS-1:0] prot_mask, erase_mask;
  logic [7:0] status;
  logic busy;

  int n_run, n_fail;
  logic tog;

  flash_op_status #(.NS(NS), .SW(SW), .PROG_US(P_PROG), .ERASE_US(P_ERASE),
    .WIN_US(P_WIN), .PPROT_US(P_PPROT), .EPROT_US(P_EPROT)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start_prog(start_prog),
    .prog_sect(prog_sect), .prog_msb(prog_msb), .start_serase(start_serase),
    .serase_sect(serase_sect), .start_cerase(start_cerase), .cmd_reset(cmd_reset),
    .cmd_other(cmd_other), .prot_mask(prot_mask), .rd_strobe(rd_strobe),
    .limit_hit(limit_hit), .status(status), .busy(busy), .erase_mask(erase_mask));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] st(input logic b7, input logic b6,
                                    input logic b5, input logic b3);
    return {b7, b6, b5, 1'b0, b3, 3'b000};
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
    us_tick = 0; start_prog = 0; start_serase = 0; start_cerase = 0;
    cmd_reset = 0; cmd_other = 0; rd_strobe = 0; limit_hit = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      us_tick = 1;
      cyc();
    end
  endtask

  task automatic rd(input logic is_busy);
    rd_strobe = 1;
    cyc();
    if (is_busy) tog = ~tog;
  endtask

  task automatic do_prog(input logic [SW-1:0] s, input logic d7, input logic prot);
    int dur;
    dur = prot ? P_PPROT : P_PROG;
    prog_sect = s; prog_msb = d7; start_prog = 1;
    cyc();
    chk("R2 busy after start", busy, 1);
    chk("R2 polling complement", status, st(~d7, tog, 1'b0, 1'b0));
    rd(1'b1);
    chk("R4 toggle while busy", status[6], tog);
    cmd_reset = 1; start_serase = 1; serase_sect = s;
    cyc();
    chk("R8 commands ignored during program", {busy, erase_mask}, {1'b1, 8'h00});
    ticks(dur - 1);
    chk(prot ? "R9 dummy still busy" : "R2 still busy", busy, 1);
    ticks(1);
    chk(prot ? "R9 dummy ended" : "R2 done", {busy, status}, {1'b0, st(d7, tog, 1'b0, 1'b0)});
    chk("R12 mask idle", erase_mask, 0);
  endtask

  task automatic finish_erase(input int dur);
    ticks(dur - 1);
    chk("R10 erase still busy", {busy, status}, {1'b1, st(1'b0, tog, 1'b0, 1'b1)});
    ticks(1);
    chk("R3 erase complete", {busy, status, erase_mask}, {1'b0, st(1'b1, tog, 1'b0, 1'b0), 8'h00});
  endtask

  initial begin
    n_run = 0; n_fail = 0; tog = 0;
    void'($urandom(32'd1234));
    rst_n = 0; us_tick = 0; start_prog = 0; start_serase = 0; start_cerase = 0;
    cmd_reset = 0; cmd_other = 0; rd_strobe = 0; limit_hit = 0;
    prog_sect = 0; prog_msb = 0; serase_sect = 0; prot_mask = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    chk("R1 reset state", {busy, status, erase_mask}, {1'b0, 8'h80, 8'h00});

    // R2/R9 random programs
    for (int i = 0; i < 10; i++) begin
      logic [SW-1:0] s;
      logic [NS-1:0] p;
      logic d;
      s = SW'($urandom % NS);
      p = NS'($urandom);
      d = 1'($urandom);
      prot_mask = p;
      do_prog(s, d, p[s]);
    end

    // R4 idle read leaves toggle
    rd(1'b0);
    chk("R4 idle read no toggle", status[6], tog);

    // R6/R10 random sector erases
    for (int i = 0; i < 6; i++) begin
      logic [NS-1:0] sel, p, eff;
      int k;
      sel = 0;
      p = NS'($urandom);
      if (i == 0) p = 8'h00;
      prot_mask = p;
      k = 1 + int'($urandom % 3);
      for (int j = 0; j < k; j++) begin
        logic [SW-1:0] s;
        s = SW'($urandom % NS);
        serase_sect = s; start_serase = 1;
        cyc();
        sel[s] = 1'b1;
        chk("R6 sector added", {busy, erase_mask, status}, {1'b1, sel, st(1'b0, tog, 1'b0, 1'b0)});
        ticks(P_WIN - 1);
      end
      chk("R6 window still open", status[3], 0);
      ticks(1);
      eff = sel & ~p;
      chk("R10 mask pruned", erase_mask, eff);
      chk("R6 erase started", status, st(1'b0, tog, 1'b0, 1'b1));
      cmd_reset = 1;
      cyc();
      chk("R8 reset ignored in erase", busy, 1);
      rd(1'b1);
      finish_erase(eff == 0 ? P_EPROT : P_ERASE);
    end

    // R6 coincidence: add on window's final tick
    prot_mask = 0;
    serase_sect = 3'd2; start_serase = 1;
    cyc();
    ticks(P_WIN - 1);
    serase_sect = 3'd6; start_serase = 1; us_tick = 1;
    cyc();
    chk("R6 add wins over expiry", {status[3], erase_mask}, {1'b0, 8'h44});
    ticks(P_WIN - 1);
    chk("R6 restarted window open", status[3], 0);
    ticks(1);
    chk("R6 window closed", status[3], 1);
    finish_erase(P_ERASE);

    // R7 aborts
    serase_sect = 3'd1; start_serase = 1;
    cyc();
    cmd_other = 1;
    cyc();
    chk("R7 abort by other", {busy, erase_mask}, {1'b0, 8'h00});
    serase_sect = 3'd5; start_serase = 1;
    cyc();
    start_prog = 1; prog_sect = 0;
    cyc();
    chk("R7 abort by program", {busy, erase_mask}, {1'b0, 8'h00});
    serase_sect = 3'd5; start_serase = 1;
    cyc();
    cmd_reset = 1;
    cyc();
    chk("R7 abort by reset", {busy, erase_mask}, {1'b0, 8'h00});

    // R11 chip erase
    prot_mask = 8'h21;
    start_cerase = 1;
    cyc();
    chk("R11 chip erase mask", {erase_mask, status}, {8'hDE, st(1'b0, tog, 1'b0, 1'b1)});
    finish_erase(P_ERASE);
    prot_mask = 8'hFF;
    start_cerase = 1;
    cyc();
    chk("R11 chip erase all protected", {busy, erase_mask}, {1'b1, 8'h00});
    finish_erase(P_EPROT);

    // R5 failure in program
    prot_mask = 0;
    prog_sect = 1; prog_msb = 1; start_prog = 1;
    cyc();
    limit_hit = 1;
    cyc();
    chk("R5 fail flag program", {busy, status}, {1'b1, st(1'b0, tog, 1'b1, 1'b0)});
    rd(1'b1);
    ticks(P_PROG + 3);
    chk("R5 fail held, toggles", {busy, status}, {1'b1, st(1'b0, tog, 1'b1, 1'b0)});
    cmd_other = 1;
    cyc();
    chk("R5 other cmd keeps fail", status[5], 1);
    cmd_reset = 1;
    cyc();
    chk("R5 reset clears fail", {busy, status[5]}, {1'b0, 1'b0});

    // R5 failure in erase
    start_cerase = 1;
    cyc();
    limit_hit = 1;
    cyc();
    chk("R5 fail flag erase", {busy, status}, {1'b1, st(1'b0, tog, 1'b1, 1'b1)});
    cmd_reset = 1;
    cyc();
    chk("R5 erase fail cleared", {busy, status[5], erase_mask}, {1'b0, 1'b0, 8'h00});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule